// File: doc/BRIEF.md
# Write-Masked Pin Function and Pull Configuration Registers

This block holds the pin-multiplexing and pull-bias settings for a group of 32-pin banks. It has two address windows. One holds 2-bit function selects, with eight pins per register. The other holds pull-disable bits, with sixteen pins per register. The flopped contents of both windows drive two flat output vectors that fan out to the pad ring.

Every register is 32 bits wide on the bus, but only the low half-word holds state. The high half-word of each write is a per-bit enable, so software changes one pin's field without reading the register first. Reads return the stored half-word with zero in the upper half. A read takes one cycle. An address that falls in neither window is accepted without effect.

Top module: `padcfg_regs`

## Requirements
- R1: On a write to a mapped register, stored bit i (0..15) takes wdata[i] only when wdata[i+16] is 1. Every bit whose enable is 0 keeps its value, including the neighbouring pin fields in the same register.
- R2: The 2-bit select of pin p (0..31) in bank b is func_sel[(b*32+p)*2 +: 2]. It lives in the register at byte address MUX_BASE + b*16 + (p/8)*4, at bits (p%8)*2+1 down to (p%8)*2.
- R3: The pull-disable bit of pin p in bank b is pull_off[b*32+p]. It lives in the register at PULL_BASE + b*8 + (p/16)*4, at bit p%16. A 1 turns the pull off and a 0 leaves the pad's default pull on.
- R4: A read loads rdata on the clock edge where rd_en is sampled high, with {16'h0000, stored half-word}. rdata keeps its value while rd_en is low, and rdata[31:16] is always zero.
- R5: After a synchronous reset, every function select is 0 (GPIO), every pull bit is 0 (default pull on) and rdata is 0.
- R6: An address that is misaligned (addr[1:0] != 0) or lies outside both windows changes no output on write and reads as zero.
- R7: Writing 0 under an enable to a pin's select returns that pin to GPIO. A read and a write to the same address in the same cycle returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Upper half: bit enables; lower half: new bit values |
| rdata | output | 32 | Registered read data, upper half zero |
| func_sel | output | NUM_BANKS*64 | Per-pin 2-bit function selects, pin 0 of bank 0 lowest |
| pull_off | output | NUM_BANKS*32 | Per-pin pull-disable bits, pin 0 of bank 0 lowest |

## Verification
Writes use several enable patterns on one register: all enables set, a single 2-bit field enabled with zero data, no enables with all-ones data, and a nibble enable. These show that enabled bits load, unenabled bits hold, and data without an enable has no effect. Single-pin writes to the first pin, a pin in the middle and the last pin of different banks show whether the bank stride, register index and bit offset are each computed correctly in both windows. Writes aimed just below, just above and between the windows, and at misaligned addresses, separate correct boundary decoding from off-by-one window edges. A read and a write to the same address in one cycle shows whether the read returns the old or the new value.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
  localparam int PINS_PER_BANK = 32;
  localparam int FSEL_W        = 2;
  localparam int HALF_W        = 16;
  localparam int PINS_PER_FREG = HALF_W / FSEL_W;
  localparam int PINS_PER_PREG = HALF_W;
  localparam int BUS_W         = 2 * HALF_W;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_MUX  = 2'd1,
    REG_PULL = 2'd2
  } region_e;
endpackage

// File: rtl/padcfg_decode.sv
module padcfg_decode
  import padcfg_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter int              MUX_REGS  = 16,
  parameter int              PULL_REGS = 8,
  parameter int              IDX_W     = 4,
  parameter logic [ADDR_W-1:0] MUX_BASE  = 'h0A8,
  parameter logic [ADDR_W-1:0] PULL_BASE = 'h118
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] MUX_SPAN  = ADDR_W'(MUX_REGS * 4);
  localparam logic [ADDR_W-1:0] PULL_SPAN = ADDR_W'(PULL_REGS * 4);

  logic [ADDR_W-1:0] mux_off;
  logic [ADDR_W-1:0] pull_off_a;
  logic              aligned;
  logic              in_mux;
  logic              in_pull;

  always_comb begin
    mux_off    = addr - MUX_BASE;
    pull_off_a = addr - PULL_BASE;
    aligned    = (addr[1:0] == 2'b00);
    in_mux     = aligned && (addr >= MUX_BASE) && (mux_off < MUX_SPAN);
    in_pull    = aligned && (addr >= PULL_BASE) && (pull_off_a < PULL_SPAN);
    region     = REG_NONE;
    idx        = '0;
    if (in_mux) begin
      region = REG_MUX;
      idx    = mux_off[IDX_W+1:2];
    end else if (in_pull) begin
      region = REG_PULL;
      idx    = pull_off_a[IDX_W+1:2];
    end
  end
endmodule

// File: rtl/padcfg_word.sv
module padcfg_word #(
  parameter int           W       = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (we) begin
      q <= (q & ~wmask) | (wbits & wmask);
    end
  end

  AST_UNENABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask)))); // R1
  AST_ENABLED_LOAD: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q & $past(wmask)) == ($past(wbits) & $past(wmask)))); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q)); // R1
endmodule

// File: rtl/padcfg_regs.sv
module padcfg_regs
  import padcfg_pkg::*;
#(
  parameter int                NUM_BANKS = 4,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] MUX_BASE  = 'h0A8,
  parameter logic [ADDR_W-1:0] PULL_BASE = 'h118
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_en,
  input  logic                                 rd_en,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic [31:0]                          wdata,
  output logic [31:0]                          rdata,
  output logic [NUM_BANKS*PINS_PER_BANK*FSEL_W-1:0] func_sel,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0]   pull_off
);
  localparam int MUX_REGS  = NUM_BANKS * PINS_PER_BANK / PINS_PER_FREG;
  localparam int PULL_REGS = NUM_BANKS * PINS_PER_BANK / PINS_PER_PREG;
  localparam int IDX_W     = $clog2(MUX_REGS);
  localparam int PIDX_W    = $clog2(PULL_REGS);

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic [HALF_W-1:0] wmask;
  logic [HALF_W-1:0] wbits;
  logic [HALF_W-1:0] mux_q  [MUX_REGS];
  logic [HALF_W-1:0] pull_q [PULL_REGS];

  assign wmask = wdata[BUS_W-1:HALF_W];
  assign wbits = wdata[HALF_W-1:0];

  padcfg_decode #(
    .ADDR_W   (ADDR_W),
    .MUX_REGS (MUX_REGS),
    .PULL_REGS(PULL_REGS),
    .IDX_W    (IDX_W),
    .MUX_BASE (MUX_BASE),
    .PULL_BASE(PULL_BASE)
  ) u_decode (
    .addr  (addr),
    .region(region),
    .idx   (idx)
  );

  for (genvar g = 0; g < MUX_REGS; g++) begin : g_mux
    logic we_g;
    assign we_g = wr_en && (region == REG_MUX) && (idx == IDX_W'(g));
    padcfg_word #(.W(HALF_W)) u_word (
      .clk  (clk),
      .rst  (rst),
      .we   (we_g),
      .wmask(wmask),
      .wbits(wbits),
      .q    (mux_q[g])
    );
    assign func_sel[g*HALF_W +: HALF_W] = mux_q[g];
  end

  for (genvar g = 0; g < PULL_REGS; g++) begin : g_pull
    logic we_g;
    assign we_g = wr_en && (region == REG_PULL) && (idx == IDX_W'(g));
    padcfg_word #(.W(HALF_W)) u_word (
      .clk  (clk),
      .rst  (rst),
      .we   (we_g),
      .wmask(wmask),
      .wbits(wbits),
      .q    (pull_q[g])
    );
    assign pull_off[g*HALF_W +: HALF_W] = pull_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (region)
        REG_MUX:  rdata <= {{HALF_W{1'b0}}, mux_q[idx]};
        REG_PULL: rdata <= {{HALF_W{1'b0}}, pull_q[idx[PIDX_W-1:0]]};
        default:  rdata <= '0;
      endcase
    end
  end

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdata[BUS_W-1:HALF_W] == '0); // R4
  AST_RD_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R4
  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && region == REG_NONE) |=> (rdata == '0)); // R6
  AST_MISS_WRITE_NOEFFECT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && region == REG_NONE) |=> ($stable(func_sel) && $stable(pull_off))); // R6
  AST_HIT_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (region != REG_NONE) |-> (addr[1:0] == 2'b00)); // R6
endmodule

// File: tb/padcfg_regs_tb.sv
module padcfg_regs_tb;
  localparam int NB     = 4;
  localparam int AW     = 12;
  localparam int MUXB   = 'h0A8;
  localparam int PULLB  = 'h118;
  localparam int NMUX   = NB * 4;
  localparam int NPULL  = NB * 2;
  localparam int FS_W   = NB * 64;
  localparam int PO_W   = NB * 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic [FS_W-1:0] func_sel;
  logic [PO_W-1:0] pull_off;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0] exp_mux  [NMUX];
  logic [15:0] exp_pull [NPULL];

  always #2.5 clk = ~clk;

  padcfg_regs #(.NUM_BANKS(NB), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .func_sel(func_sel), .pull_off(pull_off)
  );

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected vectors built pin by pin from the R2 / R3 layout rules.
  function automatic logic [FS_W-1:0] exp_fsel();
    logic [FS_W-1:0] v = '0;
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 32; p++)
        v[(b*32+p)*2 +: 2] = exp_mux[b*4 + p/8][(p%8)*2 +: 2];
    return v;
  endfunction

  function automatic logic [PO_W-1:0] exp_poff();
    logic [PO_W-1:0] v = '0;
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 32; p++)
        v[b*32+p] = exp_pull[b*2 + p/16][p%16];
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    if (a % 4 != 0) return 32'h0;
    if (a >= MUXB && a < MUXB + NMUX*4) return {16'h0, exp_mux[(a-MUXB)/4]};
    if (a >= PULLB && a < PULLB + NPULL*4) return {16'h0, exp_pull[(a-PULLB)/4]};
    return 32'h0;
  endfunction

  task automatic model_write(input int a, input logic [31:0] d);
    logic [15:0] m = d[31:16];
    if (a % 4 != 0) return;
    if (a >= MUXB && a < MUXB + NMUX*4)
      exp_mux[(a-MUXB)/4] = (exp_mux[(a-MUXB)/4] & ~m) | (d[15:0] & m);
    else if (a >= PULLB && a < PULLB + NPULL*4)
      exp_pull[(a-PULLB)/4] = (exp_pull[(a-PULLB)/4] & ~m) | (d[15:0] & m);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(input string req, input int a);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, $sformatf("read 0x%0h", a), 256'(rdata), 256'(exp_read(a)));
  endtask

  task automatic chk_outputs(input string req);
    chk(req, "func_sel", 256'(func_sel), 256'(exp_fsel()));
    chk(req, "pull_off", 256'(pull_off), 256'(exp_poff()));
  endtask

  task automatic t_reset();
    chk("R5", "func_sel after reset", 256'(func_sel), 256'h0);
    chk("R5", "pull_off after reset", 256'(pull_off), 256'h0);
    chk("R5", "rdata after reset", 256'(rdata), 256'h0);
    rd_chk("R5", MUXB);
    rd_chk("R5", PULLB + 4);
  endtask

  task automatic t_masked();
    int a = MUXB + 16 + 8;
    wr(a, 32'hFFFF_5A3C);
    chk("R1", "all enables", 256'(exp_read(a)), 256'(32'h0000_5A3C));
    rd_chk("R1", a);
    wr(a, 32'h000C_0000);
    rd_chk("R1", a);
    chk("R7", "field cleared to GPIO", 256'(func_sel[(1*32+2*8+1)*2 +: 2]), 256'(2'b00));
    wr(a, 32'h0000_FFFF);
    rd_chk("R1", a);
    wr(a, 32'h00F0_00A5);
    rd_chk("R1", a);
    chk("R1", "final value", 256'(rdata), 256'(32'h0000_5AA0));
    chk_outputs("R1");
  endtask

  task automatic t_layout();
    wr(MUXB, 32'h0003_0001);
    chk("R2", "bank0 pin0", 256'(func_sel[1:0]), 256'(2'b01));
    wr(MUXB + 3*16 + 12, 32'hC000_8000);
    chk("R2", "bank3 pin31", 256'(func_sel[(3*32+31)*2 +: 2]), 256'(2'b10));
    wr(MUXB + 2*16 + 4, 32'h0C00_0C00);
    chk("R2", "bank2 pin13", 256'(func_sel[(2*32+13)*2 +: 2]), 256'(2'b11));
    chk_outputs("R2");
    wr(MUXB + 2*16 + 4, 32'h0C00_0000);
    chk("R7", "bank2 pin13 back to GPIO", 256'(func_sel[(2*32+13)*2 +: 2]), 256'(2'b00));
  endtask

  task automatic t_pull();
    wr(PULLB + 2*8 + 4, 32'h0002_0002);
    chk("R3", "bank2 pin17 off", 256'(pull_off[2*32+17]), 256'(1'b1));
    wr(PULLB, 32'h0001_0001);
    chk("R3", "bank0 pin0 off", 256'(pull_off[0]), 256'(1'b1));
    wr(PULLB + 3*8 + 4, 32'h8000_8000);
    chk("R3", "bank3 pin31 off", 256'(pull_off[3*32+31]), 256'(1'b1));
    wr(PULLB + 2*8 + 4, 32'h0002_0000);
    chk("R3", "bank2 pin17 default pull", 256'(pull_off[2*32+17]), 256'(1'b0));
    chk_outputs("R3");
    rd_chk("R3", PULLB + 3*8 + 4);
  endtask

  task automatic t_read();
    logic [31:0] held;
    wr(MUXB + 4, 32'hFFFF_FFFF);
    rd_chk("R4", MUXB + 4);
    chk("R4", "upper half zero", 256'(rdata[31:16]), 256'h0);
    held = rdata;
    @(negedge clk); addr = AW'(PULLB);
    @(negedge clk); @(negedge clk);
    chk("R4", "rdata held while idle", 256'(rdata), 256'(held));
  endtask

  task automatic t_unmapped();
    int bad[8] = '{'h000, MUXB - 4, MUXB + NMUX*4, PULLB - 4,
                   PULLB + NPULL*4, MUXB + 1, PULLB + 2, (1 << AW) - 4};
    logic [FS_W-1:0] fs0 = func_sel;
    logic [PO_W-1:0] po0 = pull_off;
    for (int i = 0; i < 8; i++) wr(bad[i], 32'hFFFF_FFFF);
    chk("R6", "func_sel unchanged", 256'(func_sel), 256'(fs0));
    chk("R6", "pull_off unchanged", 256'(pull_off), 256'(po0));
    for (int i = 0; i < 8; i++) rd_chk("R6", bad[i]);
  endtask

  task automatic t_rdw();
    int a = MUXB + 8;
    logic [31:0] old = exp_read(a);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = AW'(a); wdata = 32'hFFFF_1234;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R7", "read during write sees old", 256'(rdata), 256'(old));
    model_write(a, 32'hFFFF_1234);
    rd_chk("R7", a);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NMUX; i++) exp_mux[i] = '0;
    for (int i = 0; i < NPULL; i++) exp_pull[i] = '0;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masked();
    t_layout();
    t_pull();
    t_read();
    t_unmapped();
    t_rdw();
    chk_outputs("R1");
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule